// File: doc/BRIEF.md
# Keyboard Wake Frame Monitor

This block listens to a keyboard's serial clock and data lines and raises a wake request when it hears one chosen key code. It runs from a slow sampling clock of about 32 kHz. Both keyboard lines pass through synchronizers before use. Each falling edge of the keyboard clock shifts one bit into an 11-bit frame. When the frame is complete, the block checks its framing and parity and compares its payload with a programmed code. A match sets a sticky flag. An event-enable input decides whether that flag drives the wake output.

If the keyboard clock stays high too long in the middle of a frame, the partial frame is dropped, so a glitch or an aborted transfer cannot line up with later bits and raise a false wake. An off input with inverted sense holds all receive state idle. Its low level, which is the default, leaves monitoring running.

Top module: `ps2_wake_monitor`

## Requirements
- R1: After reset, `matchFlag` and `wakeEvent` are both 0.
- R2: A frame is taken on 11 synchronized falling edges of `kbdClk`, sampling `kbdData` on each. The bits arrive as a start bit of 0, then the code in 8 bits with the least significant bit first, then an odd parity bit that gives the 9 bits of code plus parity an odd count of ones, then a stop bit of 1. A well-formed frame whose code equals `targetCode` sets `matchFlag` within 8 sample clocks of its last falling edge.
- R3: A well-formed frame whose code differs from `targetCode` in any bit leaves `matchFlag` clear.
- R4: A frame with a start bit of 1, a wrong parity bit or a stop bit of 0 is discarded and does not set `matchFlag`, even when its code matches.
- R5: While a frame is in progress, the synchronized keyboard clock may stay high for at most TIMEOUT_TICKS-1 sample clocks (default 3). A high period of TIMEOUT_TICKS sample clocks (default 4) drops the partial frame, and the next falling edge starts a new frame.
- R6: After its 11th falling edge the receiver returns to idle. A following frame, even one sent back to back, is received on its own.
- R7: `matchFlag` stays set until a one-cycle pulse on `clearEvt` clears it. Later non-matching frames do not clear it.
- R8: `wakeEvent` is 1 only while both `matchFlag` and `eventEn` are 1. Detection still runs and sets `matchFlag` while `eventEn` is 0.
- R9: While `logicOff` is 1, all receive state is held idle and no frame can set `matchFlag`. Once `logicOff` returns to 0, monitoring resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk32k | input | 1 | Sampling clock, about 32 kHz |
| rstN | input | 1 | Asynchronous reset, active low |
| logicOff | input | 1 | 1 turns the monitor off; 0 (default) runs it |
| eventEn | input | 1 | Lets the match flag drive the wake output |
| targetCode | input | 8 | Key code to match |
| clearEvt | input | 1 | Single-cycle pulse that clears the match flag |
| kbdClk | input | 1 | Keyboard clock line, asynchronous |
| kbdData | input | 1 | Keyboard data line, asynchronous |
| matchFlag | output | 1 | Sticky flag for a matched frame |
| wakeEvent | output | 1 | Gated wake request |

## Verification
The assertions assume that each keyboard clock low phase lasts at least two sample clocks and that data is steady across each falling edge. These are the conditions under which the synchronized edge count matches the bits sent. The stimulus changes data only while the clock is high, holds every low phase for two ticks, and uses a high phase of three ticks, the longest that does not time out. The checks on clearing also assume that a clear pulse does not land in the cycle when a frame is judged. The bench clears only several ticks after each frame ends.

// File: rtl/ps2wake_pkg.sv
package ps2wake_pkg;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic shiftEn;    // capture one data bit
    logic flush;      // drop the partial frame
    logic evalFrame;  // judge the completed frame
  } frameStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rxState_t;

endpackage

// File: rtl/ps2wake_sync.sv
module ps2wake_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hold,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else if (hold) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ps2wake_ctrl.sv
module ps2wake_ctrl
  import ps2wake_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int TIMEOUT_TICKS = 4,
  localparam int CNT_W = $clog2(FRAME_W),
  localparam int HIGH_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hold,
  input  logic              kbdClkS,
  output frameStrobe_t      strobe,
  output logic              frameBusy,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [HIGH_W-1:0] highCnt
);

  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [HIGH_W-1:0] LAST_HIGH = HIGH_W'(TIMEOUT_TICKS - 1);

  rxState_t state;
  logic prevClk;
  logic evalQ;
  logic fallEdge;
  logic timeoutHit;
  logic lastEdge;

  always_comb begin
    fallEdge   = prevClk & ~kbdClkS;
    timeoutHit = (state == ST_RECV) && kbdClkS && (highCnt == LAST_HIGH);
    lastEdge   = (state == ST_RECV) && fallEdge && (bitCnt == LAST_BIT);
    strobe.shiftEn   = fallEdge;
    strobe.flush     = timeoutHit;
    strobe.evalFrame = evalQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      highCnt <= '0;
      prevClk <= 1'b1;
      evalQ   <= 1'b0;
    end else if (hold) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      highCnt <= '0;
      prevClk <= 1'b1;
      evalQ   <= 1'b0;
    end else begin
      prevClk <= kbdClkS;
      evalQ   <= lastEdge;
      if (state != ST_RECV || !kbdClkS || timeoutHit) highCnt <= '0;
      else highCnt <= highCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state  <= ST_RECV;
            bitCnt <= CNT_W'(1);
          end
        end
        ST_RECV: begin
          if (timeoutHit) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else if (fallEdge) begin
            if (bitCnt == LAST_BIT) begin
              state  <= ST_IDLE;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frameBusy = (state == ST_RECV);

endmodule

// File: rtl/ps2wake_datapath.sv
module ps2wake_datapath
  import ps2wake_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int FRAME_W = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hold,
  input  frameStrobe_t      strobe,
  input  logic              kbdDataS,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              clearEvt,
  output logic              matchFlag
);

  logic [FRAME_W-1:0] frameQ;
  logic startOk, stopOk, parityOk, codeHit, setFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameQ <= '0;
    else if (hold || strobe.flush) frameQ <= '0;
    else if (strobe.shiftEn) frameQ <= {kbdDataS, frameQ[FRAME_W-1:1]};
  end

  always_comb begin
    startOk  = ~frameQ[0];
    stopOk   = frameQ[FRAME_W-1];
    parityOk = ^frameQ[FRAME_W-2:1];
    codeHit  = (frameQ[CODE_W:1] == targetCode);
    setFlag  = strobe.evalFrame && startOk && stopOk && parityOk && codeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchFlag <= 1'b0;
    else if (setFlag) matchFlag <= 1'b1;
    else if (clearEvt) matchFlag <= 1'b0;
  end

endmodule

// File: rtl/ps2_wake_monitor.sv
module ps2_wake_monitor
  import ps2wake_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TIMEOUT_TICKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk32k,
  input  logic              rstN,
  input  logic              logicOff,
  input  logic              eventEn,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              clearEvt,
  input  logic              kbdClk,
  input  logic              kbdData,
  output logic              matchFlag,
  output logic              wakeEvent
);

  localparam int FRAME_W = CODE_W + 3;
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int HIGH_W = $clog2(TIMEOUT_TICKS + 1);

  logic [1:0]        lineS;
  logic              kbdClkS;
  logic              kbdDataS;
  frameStrobe_t      strobe;
  logic              frameBusy;
  logic [CNT_W-1:0]  bitCnt;
  logic [HIGH_W-1:0] highCnt;

  ps2wake_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk(clk32k), .rstN(rstN), .hold(logicOff),
    .din({kbdClk, kbdData}), .dout(lineS)
  );

  assign kbdClkS  = lineS[1];
  assign kbdDataS = lineS[0];

  ps2wake_ctrl #(.FRAME_W(FRAME_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctrl (
    .clk(clk32k), .rstN(rstN), .hold(logicOff), .kbdClkS(kbdClkS),
    .strobe(strobe), .frameBusy(frameBusy), .bitCnt(bitCnt), .highCnt(highCnt)
  );

  ps2wake_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk32k), .rstN(rstN), .hold(logicOff), .strobe(strobe),
    .kbdDataS(kbdDataS), .targetCode(targetCode), .clearEvt(clearEvt),
    .matchFlag(matchFlag)
  );

  assign wakeEvent = matchFlag & eventEn;

endmodule

// File: rtl/ps2_wake_monitor_chk.sv
module ps2_wake_monitor_chk #(
  parameter int FRAME_W = 11,
  parameter int TIMEOUT_TICKS = 4,
  localparam int CNT_W = $clog2(FRAME_W),
  localparam int HIGH_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              logicOff,
  input logic              eventEn,
  input logic              clearEvt,
  input logic              matchFlag,
  input logic              wakeEvent,
  input logic              frameBusy,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [HIGH_W-1:0] highCnt,
  input logic              kbdClkS,
  input logic              evalFrame
);

  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [HIGH_W-1:0] LAST_HIGH = HIGH_W'(TIMEOUT_TICKS - 1);

  assert_wake_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    !eventEn |-> !wakeEvent);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !clearEvt |=> matchFlag);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearEvt && !evalFrame |=> !matchFlag);

  assert_timeout_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameBusy && kbdClkS && highCnt == LAST_HIGH |=> !frameBusy);

  assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  assert_idle_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    !frameBusy |-> bitCnt == '0);

  assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    logicOff |=> !frameBusy && highCnt == '0);

  assert_off_no_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    logicOff |=> ##1 !$rose(matchFlag));

endmodule

bind ps2_wake_monitor ps2_wake_monitor_chk #(
  .FRAME_W(FRAME_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)
) u_chk (
  .clk(clk32k), .rstN(rstN), .logicOff(logicOff), .eventEn(eventEn),
  .clearEvt(clearEvt), .matchFlag(matchFlag), .wakeEvent(wakeEvent),
  .frameBusy(frameBusy), .bitCnt(bitCnt), .highCnt(highCnt),
  .kbdClkS(kbdClkS), .evalFrame(strobe.evalFrame)
);

// File: tb/tb_ps2_wake_monitor.sv
module tb_ps2_wake_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_TICKS = 4;
  localparam int HIGH_T = TIMEOUT_TICKS - 1;

  logic clk32k = 1'b0;
  logic rstN = 1'b0;
  logic logicOff = 1'b0;
  logic eventEn = 1'b0;
  logic [7:0] targetCode = 8'hA5;
  logic clearEvt = 1'b0;
  logic kbdClk = 1'b1;
  logic kbdData = 1'b1;
  logic matchFlag, wakeEvent;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  ps2_wake_monitor #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) dut (
    .clk32k(clk32k), .rstN(rstN), .logicOff(logicOff), .eventEn(eventEn),
    .targetCode(targetCode), .clearEvt(clearEvt), .kbdClk(kbdClk),
    .kbdData(kbdData), .matchFlag(matchFlag), .wakeEvent(wakeEvent)
  );

  always #(CLK_PERIOD/2) clk32k = ~clk32k;

  task automatic tick(input int n);
    repeat (n) @(negedge clk32k);
  endtask

  task automatic check(input logic actual, input logic expected, input string req);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, actual, expected);
    end
  endtask

  // bit 0 start, bits 8:1 code LSB first, bit 9 odd parity, bit 10 stop
  function automatic logic [10:0] makeFrame(input logic [7:0] code, input bit badStart,
                                            input bit badPar, input bit badStop);
    logic par;
    par = ~(^code) ^ badPar;
    return {~badStop, par, code, badStart};
  endfunction

  task automatic sendBits(input logic [10:0] bits, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      kbdData = bits[i];
      tick(HIGH_T);
      kbdClk = 1'b0;
      tick(2);
      kbdClk = 1'b1;
    end
  endtask

  task automatic sendFrame(input logic [7:0] code);
    sendBits(makeFrame(code, 0, 0, 0), 11);
    tick(6);
  endtask

  task automatic pulseClear();
    clearEvt = 1'b1;
    tick(1);
    clearEvt = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk32k);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] targets [3];
    tick(3);
    check(matchFlag, 1'b0, "R1 flag after reset");
    check(wakeEvent, 1'b0, "R1 wake after reset");
    rstN = 1'b1;
    tick(3);
    check(matchFlag, 1'b0, "R1 flag after release");

    // R2/R3: full code sweep with event enable off (R8 detection still runs)
    for (int c = 0; c < 256; c++) begin
      sendFrame(8'(c));
      check(matchFlag, (8'(c) == targetCode), (8'(c) == targetCode) ? "R2 match sweep" : "R3 mismatch sweep");
      if (matchFlag) check(wakeEvent, 1'b0, "R8 wake masked");
      pulseClear();
    end

    // R2: other targets
    targets[0] = 8'h00; targets[1] = 8'hFF; targets[2] = 8'h3C;
    for (int t = 0; t < 3; t++) begin
      targetCode = targets[t];
      sendFrame(targets[t]);
      check(matchFlag, 1'b1, "R2 alt target");
      pulseClear();
      // R3: single-bit neighbours
      for (int b = 0; b < 8; b++) begin
        sendFrame(targets[t] ^ (8'h1 << b));
        check(matchFlag, 1'b0, "R3 one bit off");
      end
    end
    targetCode = 8'hA5;

    // R4: framing errors on matching code
    sendBits(makeFrame(8'hA5, 1, 0, 0), 11); tick(6);
    check(matchFlag, 1'b0, "R4 bad start");
    pulseClear();
    sendBits(makeFrame(8'hA5, 0, 1, 0), 11); tick(6);
    check(matchFlag, 1'b0, "R4 bad parity");
    pulseClear();
    sendBits(makeFrame(8'hA5, 0, 0, 1), 11); tick(6);
    check(matchFlag, 1'b0, "R4 bad stop");
    pulseClear();

    // R5: partial frame dropped after long high, next frame aligned
    sendBits(makeFrame(8'hA5, 0, 0, 0), 5);
    tick(TIMEOUT_TICKS + 1);
    sendFrame(8'hA5);
    check(matchFlag, 1'b1, "R5 timeout realigns");
    pulseClear();
    // R5: without the timeout the partial frame would misalign the next one
    sendBits(makeFrame(8'hA5, 0, 0, 0), 5);
    sendFrame(8'hA5);
    check(matchFlag, 1'b0, "R5 short high keeps partial frame");
    tick(TIMEOUT_TICKS + 2);
    pulseClear();

    // R6: back-to-back frames
    sendBits(makeFrame(8'h12, 0, 0, 0), 11);
    sendBits(makeFrame(8'hA5, 0, 0, 0), 11);
    tick(6);
    check(matchFlag, 1'b1, "R6 back to back");

    // R7: sticky across non-matching frames and idle time
    sendFrame(8'h5A);
    check(matchFlag, 1'b1, "R7 sticky after mismatch");
    tick(20);
    check(matchFlag, 1'b1, "R7 sticky idle");

    // R8: event enable gates wake
    eventEn = 1'b1;
    tick(1);
    check(wakeEvent, 1'b1, "R8 wake enabled");
    pulseClear();
    check(matchFlag, 1'b0, "R7 cleared");
    check(wakeEvent, 1'b0, "R8 wake follows flag");

    // R9: logic off ignores frames, resumes afterwards
    logicOff = 1'b1;
    tick(2);
    sendFrame(8'hA5);
    check(matchFlag, 1'b0, "R9 off ignores frame");
    check(wakeEvent, 1'b0, "R9 no wake when off");
    logicOff = 1'b0;
    tick(3);
    sendFrame(8'hA5);
    check(matchFlag, 1'b1, "R9 resumes when on");
    check(wakeEvent, 1'b1, "R8 wake after resume");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule